// File: doc/BRIEF.md
# Key-Locked Watchdog Timer

This block is the watchdog of a small 8-bit controller. It sits on a byte-wide register bus with one write strobe and an address, and exposes three registers: a control register, a key register and a status register. When armed, a counter advances on each cycle in which the slow tick-enable input (nominally 250 kHz) is high. If software does not restart the count before the selected limit is reached, the block issues a one-cycle reset request to the processor, disarms itself and raises a sticky cause flag.

The control register is write-protected. Software opens it by writing a two-byte key to the key register and closes it again with the same two bytes in the reverse order. A wrong byte at any point drops the protection back to its locked idle state. The cause flag survives the reset the block itself requests, so the reset handler can tell a watchdog reset from a power-up; only power-on reset or a software write of 0 clears it.

Register addresses: 0 = control, 1 = key, 2 = status, 3 = unused (reads 0). Reads are combinational on the address.

Top module: `wdk_top`

## Requirements
- R1: After power-on reset the control and status registers read 0x00, the reset request is low, and control writes are locked.
- R2: While locked, a write to the control register (address 0) changes nothing: the control read-back stays the same and the counter does not start.
- R3: Writing 0x1E and then 0xE1 to the key register (address 1) unlocks control writes; the unlock remains until a lock sequence or a wrong key byte.
- R4: Writing 0xE1 and then 0x1E to the key register while unlocked relocks control writes; any key byte that does not continue the expected sequence (for example 0x1E, 0x55, 0xE1) leaves or returns the block locked.
- R5: With control bit 7 (enable) set and bits 2:0 holding code c, the reset request rises after exactly 512 × 2^c counted ticks (512 at code 0, 65536 at code 7).
- R6: Only clock cycles with the tick input high advance the count; while disabled the count is held at zero.
- R7: Writing a 1 to control bit 5 restarts the count from zero, takes priority over a tick in the same cycle, and bit 5 always reads back 0.
- R8: On timeout the reset request is high for exactly one cycle, control bit 7 reads 0 afterwards, and status bit 7 reads 1.
- R9: Status bit 7 is cleared only by power-on reset or a status write with bit 7 = 0; a status write with bit 7 = 1 does not set it.
- R10: Control bits 6, 4 and 3 read as 0, and the key register and address 3 read as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Active-low power-on reset, clears all state including the cause flag |
| tick | input | 1 | Count enable, one pulse per timebase period |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| cpu_rst_req | output | 1 | One-cycle processor reset request on timeout |

## Verification
The assertions assume the bus write strobe is a clean one-cycle-per-access signal and that the tick input is synchronous to the bus clock, so a tick and a register write may land in the same cycle but never race each other. They also assume power-on reset is applied before the first access. The bench keeps to this by driving every input on the falling edge, holding each write for a single rising edge, and generating ticks either held high or from a seeded random pattern, never as glitches between edges.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
   typedef enum logic [1:0] {
      KS_LOCKED,
      KS_HALF_OPEN,
      KS_OPEN,
      KS_HALF_SHUT
   } key_state_e;

   localparam logic [1:0] ADR_CTRL = 2'd0;
   localparam logic [1:0] ADR_KEY  = 2'd1;
   localparam logic [1:0] ADR_STAT = 2'd2;

   localparam int CTRL_EN_BIT  = 7;
   localparam int CTRL_CLR_BIT = 5;
   localparam int STAT_WDR_BIT = 7;
endpackage

// File: rtl/wdk_keyfsm.sv
module wdk_keyfsm
   import wdk_pkg::*;
#(
   parameter logic [7:0] KEY_A = 8'h1E,
   parameter logic [7:0] KEY_B = 8'hE1
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       key_wr,
   input  logic [7:0] key_data,
   output logic       wr_ok
);
   key_state_e state_q, state_d;

   if (KEY_A == KEY_B) begin : g_key_chk
      $error("wdk_keyfsm: the two key bytes must differ");
   end

   always_comb begin
      state_d = state_q;
      if (key_wr) begin
         unique case (state_q)
            KS_LOCKED:    state_d = (key_data == KEY_A) ? KS_HALF_OPEN : KS_LOCKED;
            KS_HALF_OPEN: state_d = (key_data == KEY_B) ? KS_OPEN : KS_LOCKED;
            KS_OPEN:      state_d = (key_data == KEY_B) ? KS_HALF_SHUT : KS_LOCKED;
            KS_HALF_SHUT: state_d = KS_LOCKED;
            default:      state_d = KS_LOCKED;
         endcase
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) state_q <= KS_LOCKED;
      else        state_q <= state_d;
   end

   assign wr_ok = (state_q == KS_OPEN) || (state_q == KS_HALF_SHUT);

   // R3: unlocking only ever follows the second unlock byte
   a_r3_open_after_key_b: assert property (@(posedge clk) disable iff (!por_n)
      $rose(wr_ok) |-> $past(key_wr && key_data == KEY_B));

   // R4: a wrong byte while open closes the lock
   a_r4_wrong_byte_locks: assert property (@(posedge clk) disable iff (!por_n)
      (wr_ok && key_wr && key_data != KEY_B) |=> !wr_ok);
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
   parameter int BASE_LOG2 = 9,
   parameter int SEL_W     = 3,
   localparam int SEL_N    = 1 << SEL_W,
   localparam int CNT_W    = BASE_LOG2 + SEL_N - 1
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             run,
   input  logic             clr,
   input  logic             tick,
   input  logic [SEL_W-1:0] sel,
   output logic             expire
);
   logic [CNT_W-1:0] cnt;
   logic [SEL_N-1:0] hit;

   if (BASE_LOG2 < 1 || CNT_W > 31) begin : g_width_chk
      $error("wdk_counter: counter width out of range");
   end

   for (genvar g = 0; g < SEL_N; g++) begin : g_term
      localparam logic [CNT_W-1:0] LAST = CNT_W'((64'd1 << (BASE_LOG2 + g)) - 64'd1);
      assign hit[g] = (cnt == LAST);
   end

   assign expire = run && tick && !clr && hit[sel];

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                     cnt <= '0;
      else if (!run || clr || expire) cnt <= '0;
      else if (tick)                  cnt <= cnt + 1'b1;
   end

   // R6: a disabled watchdog holds its count at zero
   a_r6_idle_zero: assert property (@(posedge clk) disable iff (!por_n)
      !run |=> (cnt == '0));

   // R6: without a tick the count does not move
   a_r6_no_tick_hold: assert property (@(posedge clk) disable iff (!por_n)
      (run && !tick && !clr) |=> $stable(cnt));

   // R7: clear forces a restart
   a_r7_clear_restart: assert property (@(posedge clk) disable iff (!por_n)
      clr |=> (cnt == '0));
endmodule

// File: rtl/wdk_top.sv
module wdk_top
   import wdk_pkg::*;
#(
   parameter int         BASE_LOG2 = 9,
   parameter int         SEL_W     = 3,
   parameter logic [7:0] KEY_A     = 8'h1E,
   parameter logic [7:0] KEY_B     = 8'hE1
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       tick,
   input  logic       bus_wr,
   input  logic [1:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       cpu_rst_req
);
   logic             wr_ok, expire;
   logic             en_q, wdr_q, req_q;
   logic [SEL_W-1:0] sel_q;
   logic             ctrl_wr, stat_wr, key_wr, clr;

   if (SEL_W < 1 || SEL_W > 3) begin : g_sel_chk
      $error("wdk_top: period select must fit control bits 2:0");
   end

   assign key_wr  = bus_wr && (bus_addr == ADR_KEY);
   assign ctrl_wr = bus_wr && (bus_addr == ADR_CTRL) && wr_ok;
   assign stat_wr = bus_wr && (bus_addr == ADR_STAT);
   assign clr     = ctrl_wr && bus_wdata[CTRL_CLR_BIT];

   wdk_keyfsm #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
      .clk      (clk),
      .por_n    (por_n),
      .key_wr   (key_wr),
      .key_data (bus_wdata),
      .wr_ok    (wr_ok)
   );

   wdk_counter #(.BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W)) u_cnt (
      .clk    (clk),
      .por_n  (por_n),
      .run    (en_q),
      .clr    (clr),
      .tick   (tick),
      .sel    (sel_q),
      .expire (expire)
   );

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         en_q  <= 1'b0;
         sel_q <= '0;
         req_q <= 1'b0;
         wdr_q <= 1'b0;
      end else begin
         req_q <= expire;
         if (expire)       en_q <= 1'b0;
         else if (ctrl_wr) en_q <= bus_wdata[CTRL_EN_BIT];
         if (ctrl_wr)      sel_q <= bus_wdata[SEL_W-1:0];
         if (expire)       wdr_q <= 1'b1;
         else if (stat_wr && !bus_wdata[STAT_WDR_BIT]) wdr_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = 8'h00;
      if (bus_addr == ADR_CTRL) begin
         bus_rdata[CTRL_EN_BIT] = en_q;
         bus_rdata[SEL_W-1:0]   = sel_q;
      end else if (bus_addr == ADR_STAT) begin
         bus_rdata[STAT_WDR_BIT] = wdr_q;
      end
   end

   assign cpu_rst_req = req_q;

   // R8: reset request is a single-cycle pulse
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!por_n)
      cpu_rst_req |=> !cpu_rst_req);

   // R8: the request comes with the cause flag set and the watchdog disarmed
   a_r8_flag_and_disarm: assert property (@(posedge clk) disable iff (!por_n)
      cpu_rst_req |-> (wdr_q && !en_q));

   // R2: a locked control write leaves the control state alone
   a_r2_locked_ignored: assert property (@(posedge clk) disable iff (!por_n)
      (bus_wr && bus_addr == ADR_CTRL && !wr_ok && !expire) |=> ($stable(en_q) && $stable(sel_q)));

   // R9: the cause flag only falls on a status write of 0
   a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!por_n)
      $fell(wdr_q) |-> $past(bus_wr && bus_addr == ADR_STAT && !bus_wdata[STAT_WDR_BIT]));
endmodule

// File: tb/wdk_top_test.sv
module wdk_top_test;
   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       tick = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       cpu_rst_req;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   wdk_top uut (
      .clk(clk), .por_n(por_n), .tick(tick), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cpu_rst_req(cpu_rst_req)
   );

   function automatic int limit_of(input int code);
      return 512 << code;
   endfunction

   task automatic check(input string req, input int got, input int exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0d (0x%0h), expected %0d (0x%0h)", req, got, got, exp, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      bus_addr = a;
      #1;
      v = int'(bus_rdata);
   endtask

   task automatic unlock();
      wr(2'd1, 8'h1E);
      wr(2'd1, 8'hE1);
   endtask

   task automatic relock();
      wr(2'd1, 8'hE1);
      wr(2'd1, 8'h1E);
   endtask

   // arm with ticks held high, count edges until the request
   task automatic run_code(input int code, input string req);
      int j, v;
      tick = 1'b0;
      wr(2'd0, 8'h80 | 8'(code));
      tick = 1'b1;
      j = 0;
      do begin
         @(posedge clk); @(negedge clk);
         j++;
      end while (!cpu_rst_req && j < limit_of(code) + 4);
      check(req, j, limit_of(code));
      @(posedge clk); @(negedge clk);
      check("R8 pulse width", int'(cpu_rst_req), 0);
      tick = 1'b0;
      rd(2'd0, v); check("R8 enable cleared", v, code);
      rd(2'd2, v); check("R8 cause flag", v, 8'h80);
      wr(2'd2, 8'h00);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got hang, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int v, j, n;
      void'($urandom(1234));
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd0, v); check("R1 ctrl", v, 0);
      rd(2'd2, v); check("R1 status", v, 0);
      check("R1 request", int'(cpu_rst_req), 0);

      // R2 locked write ignored
      tick = 1'b1;
      wr(2'd0, 8'h80);
      rd(2'd0, v); check("R2 locked write", v, 0);
      repeat (600) @(negedge clk);
      check("R2 no timeout while locked", int'(cpu_rst_req), 0);
      rd(2'd2, v); check("R2 flag still clear", v, 0);
      tick = 1'b0;

      // R4 broken unlock sequence
      wr(2'd1, 8'h1E); wr(2'd1, 8'h55); wr(2'd1, 8'hE1);
      wr(2'd0, 8'h03);
      rd(2'd0, v); check("R4 broken sequence", v, 0);

      // R3 unlock, R10 unused bits
      unlock();
      wr(2'd0, 8'h7B);
      rd(2'd0, v); check("R10 unused bits and R7 clear reads 0", v, 8'h03);
      wr(2'd0, 8'h00);
      rd(2'd1, v); check("R10 key reads 0", v, 0);
      rd(2'd3, v); check("R10 addr 3 reads 0", v, 0);
      wr(2'd0, 8'h05);
      rd(2'd0, v); check("R3 unlocked write", v, 8'h05);

      // R5 R8 every period code
      for (int c = 0; c < 8; c++) run_code(c, $sformatf("R5 code %0d", c));

      // R9 writing 1 does not set the flag
      wr(2'd2, 8'h80);
      rd(2'd2, v); check("R9 write 1 no effect", v, 0);

      // R7 clear on the would-be expiry edge
      tick = 1'b0;
      wr(2'd0, 8'h81);
      tick = 1'b1;
      j = 0;
      repeat (limit_of(1) - 1) begin
         @(posedge clk); @(negedge clk);
         if (cpu_rst_req) j++;
      end
      bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'hA1;
      @(negedge clk);
      bus_wr = 1'b0;
      check("R7 no early reset", j + int'(cpu_rst_req), 0);
      j = 1;
      while (!cpu_rst_req && j < 3000) begin
         @(posedge clk); @(negedge clk);
         j++;
      end
      check("R7 restart count", j, limit_of(1) + 1);
      tick = 1'b0;
      rd(2'd2, v); check("R9 flag survives", v, 8'h80);
      wr(2'd2, 8'h00);
      rd(2'd2, v); check("R9 write 0 clears", v, 0);

      // R6 random tick pattern
      for (int c = 0; c < 2; c++) begin
         tick = 1'b0;
         wr(2'd0, 8'h80 | 8'(c));
         n = 0;
         j = 0;
         while (j == 0 && n < 20000) begin
            tick = ($urandom % 3) != 0;
            @(posedge clk);
            if (tick) n++;
            @(negedge clk);
            if (cpu_rst_req) j = n;
         end
         tick = 1'b0;
         check($sformatf("R6 random ticks code %0d", c), j, limit_of(c));
         wr(2'd2, 8'h00);
      end

      // R4 lock sequence
      relock();
      wr(2'd0, 8'h82);
      rd(2'd0, v); check("R4 relocked", v, 1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule